// File: doc/BRIEF.md
# Programmable Interval Clock Timer

This block is a 16-bit interval timer that a processor reaches through three word-sized registers. The first is a control/status word. The second is a reload buffer that can only be written. The third is the live counter, which can only be read. Software picks one of four tick sources: a fast or a slow enable divided down from the system clock, a synchronized line-frequency input, or a synchronized external input. It also picks the count direction and whether the timer reloads or stops when the counter reaches zero.

Each time the counter wraps to zero, the block raises a done flag. If done is still set from an earlier expiry that was never acknowledged, it raises an overrun error flag instead. If interrupts are enabled, the block also drives a level interrupt request. Software acknowledges by reading the control word. A single-tick strobe bit in the control word lets software step the counter by hand while the timer is halted.

The control logic is a two-state machine, HALTED and RUNNING, with three named transitions:
- **start**: a control write with run=1, taken from HALTED.
- **stop**: a control write with run=0, taken from RUNNING.
- **expire**: a zero crossing in one-shot mode, which moves RUNNING to HALTED.

A control write with run=1 while already RUNNING keeps the state. If that write changes the rate field, the time base restarts.

Top module: `prog_interval_timer`

## Requirements
- R1: Reset clears the control word, the buffer, the counter and the interrupt request. After reset every register reads 0 and `irq` is low.
- R2: Word offset 0 is the control word, 1 is the buffer, and 2 is the counter. The buffer and offset 3 read as 0, and writes to the counter or to offset 3 change nothing. Control bits are stored as follows: bit 0 run, bits 2:1 rate, bit 3 repeat, bit 4 up, bit 6 interrupt enable. Bit 5 is never stored and reads 0. Bit 7 reads done and bit 15 reads error.
- R3: A control write clears done and error and drops `irq`.
- R4: A control read returns done and error as they stood before the read, and then clears both and drops `irq`.
- R5: A buffer write loads the same value into the buffer and the counter, clears done and error, and drops `irq`.
- R6: Each tick adds 1 when bit 4 is 1 and subtracts 1 when bit 4 is 0, modulo 2^16.
- R7: When a tick leaves the counter at 0, done is set. If done was already 1, error is set instead.
- R8: A zero crossing with interrupt enable set raises `irq`. `irq` stays high until a control read, a control write, a buffer write or reset clears it.
- R9: At a zero crossing in repeat mode the counter reloads from the buffer. In one-shot mode the buffer is cleared and run drops to 0.
- R10: Rate 00 ticks every CLK_HZ/100000 cycles and rate 01 every CLK_HZ/10000 cycles. These periods restart at a control write that starts the timer or changes the rate while it runs.
- R11: Rate 10 ticks once per rising edge of `line_tick`, and rate 11 ticks once per rising edge of `ext_tick`. Each input passes through a two-flop synchronizer first.
- R12: A control write with bit 5 set and run 0 gives exactly one immediate tick, using the newly written direction, enable and mode. With run 1, bit 5 gives no tick.
- R13: In a cycle with any register write, a source tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Word offset of the register accessed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the control word) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_sel` |
| line_tick | input | 1 | Asynchronous line-frequency tick input |
| ext_tick | input | 1 | Asynchronous external tick input |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the following about the inputs:
- `reg_wr` and `reg_rd` are single-cycle strobes.
- A read and a write never coincide.
- A tick input held high stays high long enough to clear the synchronizer.
- `CLK_HZ` divides into both fast and slow periods of at least two cycles.

The bench respects these assumptions. It drives every access for exactly one cycle from the falling edge, and it holds each tick input for four cycles high and four low. It elaborates the timer with a 1 MHz clock parameter so that both prescaler periods are short and known exactly. It samples `reg_rdata` combinationally before the edge that performs the read side effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int REG_W = 16;
    localparam int SEL_W = 2;

    localparam logic [SEL_W-1:0] SEL_CTRL = 2'd0;
    localparam logic [SEL_W-1:0] SEL_BUF  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_CNT  = 2'd2;

    localparam int B_RUN    = 0;
    localparam int B_RATE   = 1;
    localparam int B_REPEAT = 3;
    localparam int B_UP     = 4;
    localparam int B_STROBE = 5;
    localparam int B_IE     = 6;
    localparam int B_DONE   = 7;
    localparam int B_ERR    = 15;

    typedef enum logic {
        ST_HALTED  = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        RATE_FAST = 2'd0,
        RATE_SLOW = 2'd1,
        RATE_LINE = 2'd2,
        RATE_EXT  = 2'd3
    } rate_e;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic pulse
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign pulse = (cnt_q == LAST) && !restart;

    // R10: a period of two or more cycles never yields back-to-back pulses
    assert_pulse_spaced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    output logic [1:0] rate_pulse
);
    localparam int FAST_HZ = 100_000;
    localparam int SLOW_HZ = 10_000;

    for (genvar i = 0; i < 2; i++) begin : g_div
        localparam int DIV = CLK_HZ / ((i == 0) ? FAST_HZ : SLOW_HZ);
        tmr_divider #(.DIV(DIV)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .pulse   (rate_pulse[i])
        );
    end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R11: one rising edge yields a single-cycle tick
    assert_single_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
    import tmr_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             line_tick,
    input  logic             ext_tick,
    output logic             irq
);
    run_state_e       state_q, state_d;
    rate_e            rate_q, rate_d;
    logic             repeat_q, repeat_d;
    logic             up_q, up_d;
    logic             ie_q, ie_d;
    logic             done_q, done_d;
    logic             err_q, err_d;
    logic             irq_q, irq_d;
    logic [REG_W-1:0] buf_q, buf_d;
    logic [REG_W-1:0] cnt_q, cnt_d;

    logic [1:0] rate_pulse;
    logic [1:0] pin_rise;
    logic       restart;
    logic       src_tick;
    logic       tick_go;
    logic       wr_ctrl, wr_buf, rd_ctrl;
    logic [REG_W-1:0] stepped;

    assign wr_ctrl = reg_wr && reg_sel == SEL_CTRL;
    assign wr_buf  = reg_wr && reg_sel == SEL_BUF;
    assign rd_ctrl = reg_rd && !reg_wr && reg_sel == SEL_CTRL;

    // time base restarts on start or on a rate change while running
    assign restart = wr_ctrl && reg_wdata[B_RUN] &&
                     (state_q == ST_HALTED || reg_wdata[B_RATE+:2] != rate_q);

    tmr_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .rate_pulse (rate_pulse)
    );

    for (genvar i = 0; i < 2; i++) begin : g_pin
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in ((i == 0) ? line_tick : ext_tick),
            .rise     (pin_rise[i])
        );
    end

    always_comb begin
        unique case (rate_q)
            RATE_FAST: src_tick = rate_pulse[0];
            RATE_SLOW: src_tick = rate_pulse[1];
            RATE_LINE: src_tick = pin_rise[0];
            RATE_EXT:  src_tick = pin_rise[1];
        endcase
    end

    // next-state and register update logic
    always_comb begin
        state_d  = state_q;
        rate_d   = rate_q;
        repeat_d = repeat_q;
        up_d     = up_q;
        ie_d     = ie_q;
        done_d   = done_q;
        err_d    = err_q;
        irq_d    = irq_q;
        buf_d    = buf_q;
        cnt_d    = cnt_q;

        if (rd_ctrl) begin
            done_d = 1'b0;
            err_d  = 1'b0;
            irq_d  = 1'b0;
        end
        if (wr_ctrl) begin
            state_d  = reg_wdata[B_RUN] ? ST_RUNNING : ST_HALTED;
            rate_d   = rate_e'(reg_wdata[B_RATE+:2]);
            repeat_d = reg_wdata[B_REPEAT];
            up_d     = reg_wdata[B_UP];
            ie_d     = reg_wdata[B_IE];
            done_d   = 1'b0;
            err_d    = 1'b0;
            irq_d    = 1'b0;
        end
        if (wr_buf) begin
            buf_d  = reg_wdata;
            cnt_d  = reg_wdata;
            done_d = 1'b0;
            err_d  = 1'b0;
            irq_d  = 1'b0;
        end

        if (wr_ctrl)
            tick_go = !reg_wdata[B_RUN] && reg_wdata[B_STROBE];
        else
            tick_go = !reg_wr && state_q == ST_RUNNING && src_tick;

        stepped = up_d ? cnt_d + 1'b1 : cnt_d - 1'b1;
        if (tick_go) begin
            cnt_d = stepped;
            if (stepped == '0) begin
                if (done_d) err_d  = 1'b1;
                else        done_d = 1'b1;
                if (ie_d) irq_d = 1'b1;
                if (repeat_d) begin
                    cnt_d = buf_d;
                end else begin
                    buf_d   = '0;
                    state_d = ST_HALTED;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_d;
    end

    // data and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= RATE_FAST;
            repeat_q <= 1'b0;
            up_q     <= 1'b0;
            ie_q     <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            irq_q    <= 1'b0;
            buf_q    <= '0;
            cnt_q    <= '0;
        end else begin
            rate_q   <= rate_d;
            repeat_q <= repeat_d;
            up_q     <= up_d;
            ie_q     <= ie_d;
            done_q   <= done_d;
            err_q    <= err_d;
            irq_q    <= irq_d;
            buf_q    <= buf_d;
            cnt_q    <= cnt_d;
        end
    end

    assign irq = irq_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTRL: begin
                reg_rdata[B_RUN]      = (state_q == ST_RUNNING);
                reg_rdata[B_RATE+:2]  = rate_q;
                reg_rdata[B_REPEAT]   = repeat_q;
                reg_rdata[B_UP]       = up_q;
                reg_rdata[B_IE]       = ie_q;
                reg_rdata[B_DONE]     = done_q;
                reg_rdata[B_ERR]      = err_q;
            end
            SEL_CNT: reg_rdata = cnt_q;
            default: reg_rdata = '0;
        endcase
    end

    // R8: interrupt only rises while enabled
    assert_irq_needs_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ie_q);
    // R7: overrun only follows an unacknowledged done
    assert_err_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(done_q));
    // R2: counter offset is read-only
    assert_cnt_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CNT) |=> cnt_q == $past(cnt_q));
    // R5: buffer write loads both copies and acknowledges
    assert_buf_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_buf |=> (cnt_q == $past(reg_wdata) && buf_q == $past(reg_wdata) && !irq && !done_q));
    // R4: control read acknowledges when no tick lands in the same cycle
    assert_ctrl_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !tick_go) |=> (!irq && !done_q && !err_q));
    // R9: one-shot expiry halts and empties the buffer
    assert_oneshot_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_q) && !repeat_q) |-> (state_q == ST_HALTED && buf_q == '0));
endmodule

// File: tb/prog_interval_timer_bench.sv
module prog_interval_timer_bench;
    localparam int CLK_HZ   = 1_000_000;
    localparam int FAST_DIV = CLK_HZ / 100_000;
    localparam int SLOW_DIV = CLK_HZ / 10_000;
    localparam int WATCHDOG = 100_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        line_tick = 1'b0;
    logic        ext_tick = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prog_interval_timer #(.CLK_HZ(CLK_HZ)) u_prog_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .line_tick (line_tick),
        .ext_tick  (ext_tick),
        .irq       (irq)
    );

    typedef struct packed {
        logic        is_rd;
        logic [1:0]  sel;
        logic [15:0] data;
        logic [15:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R1 control after reset
        '{1'b1, 2'd2, 16'h0000, 16'h0000, 1'b0}, // R1 counter after reset
        '{1'b0, 2'd1, 16'h0002, 16'h0000, 1'b0}, // R5 buffer load
        '{1'b1, 2'd2, 16'h0000, 16'h0002, 1'b0}, // R5 counter follows buffer
        '{1'b1, 2'd1, 16'h0000, 16'h0000, 1'b0}, // R2 buffer reads zero
        '{1'b0, 2'd2, 16'h1234, 16'h0000, 1'b0}, // R2 counter write
        '{1'b1, 2'd2, 16'h0000, 16'h0002, 1'b0}, // R2 counter unchanged
        '{1'b0, 2'd0, 16'h0020, 16'h0000, 1'b0}, // R12 strobe down
        '{1'b1, 2'd2, 16'h0000, 16'h0001, 1'b0}, // R12 one tick
        '{1'b1, 2'd0, 16'h0000, 16'h0000, 1'b0}, // R2 strobe not stored
        '{1'b0, 2'd0, 16'h0060, 16'h0000, 1'b1}, // R8 strobe to zero with IE
        '{1'b1, 2'd2, 16'h0000, 16'h0000, 1'b1}, // R7 counter at zero
        '{1'b1, 2'd0, 16'h0000, 16'h00C0, 1'b0}, // R4 flags seen then cleared
        '{1'b1, 2'd0, 16'h0000, 16'h0040, 1'b0}, // R4 done gone
        '{1'b0, 2'd1, 16'h0001, 16'h0000, 1'b0}, // R5
        '{1'b0, 2'd0, 16'h0068, 16'h0000, 1'b1}, // R9 repeat expiry
        '{1'b1, 2'd2, 16'h0000, 16'h0001, 1'b1}, // R9 reloaded
        '{1'b0, 2'd0, 16'h0048, 16'h0000, 1'b0}, // R3 control write drops irq
        '{1'b1, 2'd0, 16'h0000, 16'h0048, 1'b0}, // R3 done cleared
        '{1'b0, 2'd0, 16'h0068, 16'h0000, 1'b1}, // R8 expiry again
        '{1'b0, 2'd1, 16'h0003, 16'h0000, 1'b0}, // R5 buffer write drops irq
        '{1'b1, 2'd0, 16'h0000, 16'h0048, 1'b0}, // R5 done cleared
        '{1'b0, 2'd1, 16'hFFFF, 16'h0000, 1'b0}, // R6
        '{1'b0, 2'd0, 16'h0030, 16'h0000, 1'b0}, // R6 up wraps to zero
        '{1'b1, 2'd2, 16'h0000, 16'h0000, 1'b0}, // R6
        '{1'b1, 2'd0, 16'h0000, 16'h0090, 1'b0}, // R7 done, run cleared
        '{1'b0, 2'd1, 16'h0005, 16'h0000, 1'b0}, // R6
        '{1'b0, 2'd0, 16'h0030, 16'h0000, 1'b0}, // R6 up step
        '{1'b1, 2'd2, 16'h0000, 16'h0006, 1'b0}, // R6
        '{1'b0, 2'd0, 16'h005E, 16'h0000, 1'b0}, // R2 all stored bits
        '{1'b1, 2'd0, 16'h0000, 16'h005E, 1'b0}, // R2 readback
        '{1'b0, 2'd1, 16'h0000, 16'h0000, 1'b0}, // R6
        '{1'b0, 2'd0, 16'h0020, 16'h0000, 1'b0}, // R6 down wraps
        '{1'b1, 2'd2, 16'h0000, 16'hFFFF, 1'b0}  // R6
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] sel, input logic [15:0] exp);
        logic [15:0] v;
        rd(sel, v);
        check(tag, v, exp);
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic pin_pulse(input bit which);
        @(negedge clk);
        if (which) ext_tick = 1'b1; else line_tick = 1'b1;
        repeat (4) @(negedge clk);
        if (which) ext_tick = 1'b0; else line_tick = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(WATCHDOG * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {15'd0, irq}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            if (TBL[i].is_rd) begin
                rd(TBL[i].sel, v);
                check($sformatf("R2-table entry %0d read", i), v, TBL[i].exp_rd);
            end else begin
                wr(TBL[i].sel, TBL[i].data);
            end
            check($sformatf("R8-table entry %0d irq", i), {15'd0, irq}, {15'd0, TBL[i].exp_irq});
        end

        // R10 fast rate: after the start write, ticks every FAST_DIV edges
        wr(2'd1, 16'd100);
        wr(2'd0, 16'h0001);
        edges(3 * FAST_DIV + 5);
        rd_check("R10 fast rate three ticks", 2'd2, 16'd97);
        // R10 rate change restarts the slow period
        wr(2'd0, 16'h0003);
        edges(SLOW_DIV - 5);
        rd_check("R10 slow rate before period", 2'd2, 16'd97);
        edges(9);
        rd_check("R10 slow rate after period", 2'd2, 16'd96);
        // R12 strobe while running gives no tick
        wr(2'd0, 16'h0023);
        rd_check("R12 strobe ignored while running", 2'd2, 16'd96);
        wr(2'd0, 16'h0000);

        // R11 line ticks, R7 overrun on second expiry
        wr(2'd1, 16'd1);
        wr(2'd0, 16'h000D);
        pin_pulse(1'b0);
        pin_pulse(1'b0);
        rd_check("R7 overrun flag set", 2'd0, 16'h808D);
        rd_check("R11 repeat reload after line ticks", 2'd2, 16'd1);
        wr(2'd0, 16'h001F);
        pin_pulse(1'b1);
        rd_check("R11 external edge counts up", 2'd2, 16'd2);
        pin_pulse(1'b0);
        rd_check("R11 line edge ignored on external rate", 2'd2, 16'd2);

        // R13 buffer write coincides with a synchronized line tick
        wr(2'd0, 16'h0005);
        @(negedge clk);
        line_tick = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_sel = 2'd1; reg_wdata = 16'd7; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        line_tick = 1'b0;
        repeat (4) @(negedge clk);
        rd_check("R13 write wins over tick", 2'd2, 16'd7);

        // R9 one-shot running expiry with R8 held interrupt
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0041);
        edges(3 * FAST_DIV + 20);
        @(negedge clk);
        check("R8 irq held after expiry", {15'd0, irq}, 16'd1);
        rd_check("R9 one-shot counter at zero", 2'd2, 16'd0);
        rd_check("R9 run cleared at expiry", 2'd0, 16'h00C0);
        edges(3 * FAST_DIV);
        rd_check("R9 halted counter stays", 2'd2, 16'd0);

        // R1 reset in mid-operation
        wr(2'd1, 16'd50);
        wr(2'd0, 16'h0069);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1 control cleared", 2'd0, 16'h0000);
        rd_check("R1 counter cleared", 2'd2, 16'h0000);
        check("R1 irq cleared", {15'd0, irq}, 16'd0);

        finish_run();
    end
endmodule